// File: doc/BRIEF.md
# Transparent March Memory Self-Test Controller

This controller runs a March C self-test on a synchronous single-port RAM while keeping the user data in it. No fixed background pattern is written, so the RAM does not have to be reloaded after the test. Every test value is taken relative to the cell's own content `v`. A base operation "write x" becomes a write of `x ^ v`. A base operation "read x" expects `x ^ v`. The first element only reads. After the last element each cell holds `v` again, because each cell has been complemented exactly four times.

The test runs in two passes over the same six-element sequence. In the prediction pass no writes are issued. Each read value is XORed with the March value that the base test expects at that point, and the result is fed into a multiple-input signature register (MISR). In the test pass the full read/write sequence runs and the raw read data goes into the same MISR, starting from the same seed. A fault-free RAM gives identical signatures. When the sequence ends, `done` rises, and `fail` rises with it if the signatures differ. Both stay until the next `start`.

The transparent element list is:
- E0: ascending, read
- E1: ascending, read and write complement
- E2: ascending, read and write complement
- E3: descending, read and write complement
- E4: descending, read and write complement
- E5: ascending, read

The expected base values are 0, 0, 1, 0, 1, 0 for E0 to E5. The states are:
- IDLE
- READ (issue a read)
- CAPT (take the read data, compress it, and write back if the element writes)
- NEXT (advance to the next element or the next pass)
- DONE

The transitions are:
- IDLE→READ on `start`
- READ→CAPT always
- CAPT→READ while addresses remain in the element
- CAPT→NEXT at the last address of the element
- NEXT→READ while elements or the test pass remain
- NEXT→DONE after E5 of the test pass
- DONE→READ on `start`

Top module: `tmarch_bist`

## Requirements
- R1: After reset, `done`, `fail`, `mem_en` and `mem_we` are all 0.
- R2: The prediction pass issues no write. The first write of a run comes after exactly 7*DEPTH+1 reads: six read-only sweeps, the test-pass E0 sweep, and the first E1 read.
- R3: Every write goes to the address of the read issued in the previous cycle, and its data is the bitwise complement of the word currently stored there.
- R4: The writes of a run visit addresses in this order: ascending 0..DEPTH-1 twice, then descending DEPTH-1..0 twice.
- R5: A run issues exactly 4*DEPTH writes, and on a fault-free RAM every word holds its pre-test value afterwards.
- R6: `done` rises 2*6*(2*DEPTH+1) clock cycles after the clock edge that samples `start` in IDLE.
- R7: On a fault-free RAM `fail` stays 0. A single bit stuck at 0 or 1 in any word makes `fail` 1 when `done` rises.
- R8: `start` is ignored while a run is in progress. It neither shortens nor lengthens the run and does not change its result.
- R9: `done` and `fail` hold their values until `start` is sampled in DONE. `done` falls one cycle after that, and the new run repeats the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled in IDLE and DONE) |
| mem_en | output | 1 | Read strobe; read data returns on `mem_rdata` the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, one cycle after `mem_en` |
| done | output | 1 | Run finished |
| fail | output | 1 | Signatures differed (valid with `done`) |

## Verification
The hardest situation to reach from the ports is a fault whose effect shows only in the signature. A stuck cell reads back its forced value in both passes. Only in E2 and E4 does the value it reads differ from the one predicted in the prediction pass.

To reach it, the bench's RAM model forces one bit of one word on both read and write. It sweeps this fault over the first, a middle and the last word, over the lowest and highest bit, and over both polarities.

Fault-free runs on several data backgrounds then show that the content is restored and that `fail` stays low. A run with `start` pulsed mid-test shows that the run length and the result do not change.

// File: rtl/tmarch_pkg.sv
package tmarch_pkg;

    localparam int NUM_ELEM = 6;
    localparam int ELEM_W   = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPT,
        ST_NEXT,
        ST_DONE
    } tm_state_e;

    // Expected base read value of an element (before XOR with cell content)
    function automatic logic elem_expect(input logic [ELEM_W-1:0] e);
        return (e == 3'd2) || (e == 3'd4);
    endfunction

    // Base write value of an element
    function automatic logic elem_wval(input logic [ELEM_W-1:0] e);
        return (e == 3'd1) || (e == 3'd3);
    endfunction

    // Element performs a write after its read
    function automatic logic elem_writes(input logic [ELEM_W-1:0] e);
        return (e >= 3'd1) && (e <= 3'd4);
    endfunction

    // Element sweeps addresses from high to low
    function automatic logic elem_down(input logic [ELEM_W-1:0] e);
        return (e == 3'd3) || (e == 3'd4);
    endfunction

endpackage

// File: rtl/tmarch_addr_seq.sv
module tmarch_addr_seq #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          load_down,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_end
);
    localparam logic [AW-1:0] ADDR_MAX = {AW{1'b1}};

    logic [AW-1:0] addr_q;
    logic          down_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            addr_q <= load_down ? ADDR_MAX : '0;
            down_q <= load_down;
        end else if (step) begin
            addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
        end
    end

    assign addr   = addr_q;
    assign at_end = down_q ? (addr_q == '0) : (addr_q == ADDR_MAX);

endmodule

// File: rtl/tmarch_misr.sv
module tmarch_misr #(
    parameter int            DW   = 8,
    parameter logic [DW-1:0] POLY = 8'h1D,
    parameter logic [DW-1:0] SEED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          en,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] sig
);
    logic [DW-1:0] sig_q;
    logic [DW-1:0] shifted;

    always_comb begin
        shifted = {sig_q[DW-2:0], 1'b0};
        if (sig_q[DW-1]) begin
            shifted = shifted ^ POLY;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= SEED;
        end else if (clear) begin
            sig_q <= SEED;
        end else if (en) begin
            sig_q <= shifted ^ din;
        end
    end

    assign sig = sig_q;

endmodule

// File: rtl/tmarch_bist.sv
module tmarch_bist
    import tmarch_pkg::*;
#(
    parameter int            AW   = 8,
    parameter int            DW   = 8,
    parameter logic [DW-1:0] POLY = 8'h1D,
    parameter logic [DW-1:0] SEED = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic          fail
);
    localparam logic [ELEM_W-1:0] LAST_ELEM = ELEM_W'(NUM_ELEM - 1);

    tm_state_e         state_q, state_d;
    logic              pass_q;
    logic [ELEM_W-1:0] elem_q;
    logic [DW-1:0]     pred_q;
    logic              fail_q;

    logic              ag_load, ag_down, ag_step, ag_end;
    logic [AW-1:0]     ag_addr;
    logic              sg_clear, sg_en;
    logic [DW-1:0]     sg_din, sg_sig;

    logic              run_end;
    logic [ELEM_W-1:0] elem_nx;

    tmarch_addr_seq #(.AW(AW)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ag_load),
        .load_down(ag_down),
        .step     (ag_step),
        .addr     (ag_addr),
        .at_end   (ag_end)
    );

    tmarch_misr #(.DW(DW), .POLY(POLY), .SEED(SEED)) u_misr (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(sg_clear),
        .en   (sg_en),
        .din  (sg_din),
        .sig  (sg_sig)
    );

    assign run_end = pass_q && (elem_q == LAST_ELEM);
    assign elem_nx = (elem_q == LAST_ELEM) ? '0 : elem_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pass_q  <= 1'b0;
            elem_q  <= '0;
            pred_q  <= '0;
            fail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        pass_q <= 1'b0;
                        elem_q <= '0;
                        fail_q <= 1'b0;
                    end
                end
                ST_NEXT: begin
                    if (run_end) begin
                        fail_q <= (sg_sig != pred_q);
                    end else begin
                        elem_q <= elem_nx;
                        if (elem_q == LAST_ELEM) begin
                            pass_q <= 1'b1;
                            pred_q <= sg_sig;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_READ;
            ST_READ: state_d = ST_CAPT;
            ST_CAPT: state_d = ag_end ? ST_NEXT : ST_READ;
            ST_NEXT: state_d = run_end ? ST_DONE : ST_READ;
            ST_DONE: if (start) state_d = ST_READ;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath controls
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = mem_rdata ^ {DW{elem_expect(elem_q) ^ elem_wval(elem_q)}};
        ag_load   = 1'b0;
        ag_down   = 1'b0;
        ag_step   = 1'b0;
        sg_clear  = 1'b0;
        sg_en     = 1'b0;
        sg_din    = pass_q ? mem_rdata : (mem_rdata ^ {DW{elem_expect(elem_q)}});
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    ag_load  = 1'b1;
                    ag_down  = elem_down('0);
                    sg_clear = 1'b1;
                end
            end
            ST_READ: mem_en = 1'b1;
            ST_CAPT: begin
                sg_en   = 1'b1;
                mem_we  = pass_q && elem_writes(elem_q);
                ag_step = !ag_end;
            end
            ST_NEXT: begin
                if (!run_end) begin
                    ag_load  = 1'b1;
                    ag_down  = elem_down(elem_nx);
                    sg_clear = (elem_q == LAST_ELEM);
                end
            end
            default: ;
        endcase
    end

    assign mem_addr = ag_addr;
    assign done     = (state_q == ST_DONE);
    assign fail     = done && fail_q;

endmodule

// File: rtl/tmarch_bist_chk.sv
module tmarch_bist_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_en,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          fail,
    input logic          pass_q
);
    // R2
    no_write_in_predict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> pass_q);

    // R3
    write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(mem_en) && mem_addr == $past(mem_addr)));

    // R3
    no_read_write_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_en && mem_we));

    // R7
    fail_only_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R9
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(fail)));

    // R9
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (!done && mem_en));

    // R1
    quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_en && !mem_we));

endmodule

bind tmarch_bist tmarch_bist_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mem_en  (mem_en),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .done    (done),
    .fail    (fail),
    .pass_q  (pass_q)
);

// File: tb/sim_tmarch_bist.sv
module sim_tmarch_bist;
    localparam int AW    = 4;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int RUN_CYC = 2 * 6 * (2 * DEPTH + 1);
    localparam int LIMIT   = 4 * RUN_CYC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          mem_en, mem_we, done, fail;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;

    always #2 clk = ~clk;

    tmarch_bist #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .fail(fail)
    );

    // RAM model with optional stuck bit
    logic [DW-1:0] ram [DEPTH];
    logic [DW-1:0] saved [DEPTH];
    logic          flt_on = 1'b0;
    logic [AW-1:0] flt_addr = '0;
    logic [DW-1:0] flt_mask = '0;
    logic          flt_val = 1'b0;
    logic          preload = 1'b0;
    logic [DW-1:0] pre_word [DEPTH];

    function automatic logic [DW-1:0] force_bit(input logic [AW-1:0] a, input logic [DW-1:0] d);
        if (flt_on && a == flt_addr)
            return (d & ~flt_mask) | (flt_val ? flt_mask : '0);
        return d;
    endfunction

    always @(posedge clk) begin
        if (preload) begin
            for (int i = 0; i < DEPTH; i++) ram[i] <= pre_word[i];
        end else if (mem_we) begin
            ram[mem_addr] <= force_bit(mem_addr, mem_wdata);
        end
        if (mem_en) mem_rdata <= force_bit(mem_addr, ram[mem_addr]);
    end

    // port monitor
    logic mon_clr = 1'b0;
    int   n_reads, n_writes, reads_at_first_wr, addr_err, data_err;
    always @(negedge clk) begin
        if (mon_clr) begin
            n_reads = 0; n_writes = 0; reads_at_first_wr = -1;
            addr_err = 0; data_err = 0;
        end else begin
            if (mem_en && !mem_we) n_reads++;
            if (mem_we) begin
                automatic int seg = n_writes / DEPTH;
                automatic int off = n_writes % DEPTH;
                automatic int ea  = (seg < 2) ? off : DEPTH - 1 - off;
                if (reads_at_first_wr < 0) reads_at_first_wr = n_reads;
                if (int'(mem_addr) != ea) addr_err++;
                if (!flt_on && mem_wdata != ~ram[mem_addr]) data_err++;
                n_writes++;
            end
        end
    end

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_ram(input int kind);
        for (int i = 0; i < DEPTH; i++) begin
            case (kind)
                0: pre_word[i] = DW'($urandom);
                1: pre_word[i] = '0;
                2: pre_word[i] = '1;
                default: pre_word[i] = (i % 2) ? DW'(8'hA5) : DW'(8'h5A);
            endcase
            saved[i] = pre_word[i];
        end
        @(negedge clk) preload = 1'b1;
        @(negedge clk) preload = 1'b0;
    endtask

    task automatic run_once(input bit mid_start, output int cycles);
        @(negedge clk) begin mon_clr = 1'b1; start = 1'b1; end
        @(posedge clk);
        @(negedge clk) begin mon_clr = 1'b0; start = 1'b0; end
        cycles = 0;
        while (!done && cycles < LIMIT) begin
            @(posedge clk);
            cycles++;
            @(negedge clk);
            if (mid_start) start = (cycles == 50);
        end
        start = 1'b0;
        if (cycles >= LIMIT) chk(1'b0, "watchdog", cycles, RUN_CYC);
    endtask

    task automatic check_restored(input string req);
        int bad = 0;
        for (int i = 0; i < DEPTH; i++) if (ram[i] != saved[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        int cyc;
        int wrong;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(fail == 1'b0, "R1 fail", int'(fail), 0);
        chk(mem_en == 1'b0 && mem_we == 1'b0, "R1 strobes", int'({mem_en, mem_we}), 0);
        rst_n = 1'b1;

        // fault-free run on random data
        load_ram(0);
        run_once(1'b0, cyc);
        chk(cyc == RUN_CYC, "R6 done latency", cyc, RUN_CYC);
        chk(reads_at_first_wr == 7 * DEPTH + 1, "R2 reads before first write", reads_at_first_wr, 7 * DEPTH + 1);
        chk(data_err == 0, "R3 write data complement", data_err, 0);
        chk(addr_err == 0, "R4 write address order", addr_err, 0);
        chk(n_writes == 4 * DEPTH, "R5 write count", n_writes, 4 * DEPTH);
        check_restored("R5 content restored");
        chk(done && !fail, "R7 fault-free pass", int'(fail), 0);

        // R9 hold
        repeat (7) @(negedge clk);
        chk(done == 1'b1 && fail == 1'b0, "R9 done held", int'(done), 1);

        // other backgrounds
        for (int k = 1; k < 4; k++) begin
            load_ram(k);
            run_once(1'b0, cyc);
            chk(done && !fail, "R7 background pass", int'(fail), 0);
            check_restored("R5 background restored");
            chk(n_writes == 4 * DEPTH, "R5 background writes", n_writes, 4 * DEPTH);
        end

        // R8 start during run
        load_ram(0);
        run_once(1'b1, cyc);
        chk(cyc == RUN_CYC, "R8 length unchanged", cyc, RUN_CYC);
        chk(done && !fail, "R8 result unchanged", int'(fail), 0);
        check_restored("R8 content restored");

        // R7 stuck-at sweep
        wrong = 0;
        for (int ai = 0; ai < 3; ai++) begin
            for (int b = 0; b < 2; b++) begin
                for (int s = 0; s < 2; s++) begin
                    load_ram(0);
                    flt_on   = 1'b1;
                    flt_addr = AW'((ai == 0) ? 0 : (ai == 1) ? DEPTH / 2 - 3 : DEPTH - 1);
                    flt_mask = DW'(1) << ((b == 0) ? 0 : DW - 1);
                    flt_val  = s[0];
                    run_once(1'b0, cyc);
                    chk(done && fail, "R7 stuck-at detected", int'(fail), 1);
                    flt_on = 1'b0;
                end
            end
        end

        // R9 restart after a failing run, done falls one cycle after start
        load_ram(0);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        chk(done == 1'b0, "R9 done falls", int'(done), 0);
        cyc = 0;
        while (!done && cyc < LIMIT) begin @(posedge clk); cyc++; @(negedge clk); end
        chk(cyc == RUN_CYC, "R9 rerun latency", cyc, RUN_CYC);
        chk(done && !fail, "R9 rerun passes", int'(fail), 0);
        check_restored("R9 rerun restored");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule